// File: doc/BRIEF.md
# Clock Buffer Power Sequencer

This block sequences the start-up and shutdown of a differential clock fan-out buffer. After the supply-good flag rises, it waits a fixed settling delay. It then holds the outputs off until the power-down request is released. In PLL mode it also waits until the input clock is valid and the PLL has reported lock for an unbroken stretch of cycles. Only then does it turn on the global output enable and raise a lock flag. In bypass mode the clock and lock conditions are skipped.

Shutdown is deliberately slow and clean. The power-down request must be seen on two successive rising edges of the complement output clock. The outputs are parked on the falling edge that follows. While parked, a register bit chooses between two output states: the true phase is driven high and the complement left floating, or both phases float. After a park the sequencer goes back to waiting, and it restarts once the request is released. The lock flag is sticky: it ignores the PLL status and clears only when the outputs are parked or the supply drops.

All timing runs on a reference clock. The power-down pin and the complement output clock arrive asynchronously and are synchronised inside the block. The PLL and the analog supply detector are modelled as flags.

Top module: `bufpwr_seq`

## Requirements
- R1: While `rst` is high, `out_en` and `lock` are 0 and `drive_sel` is 2 (both phases floating).
- R2: A cycle with `supply_ok` low forces `out_en` and `lock` to 0 and `drive_sel` to 2 by the next clock edge, from any state.
- R3: After `supply_ok` rises, `out_en` stays 0 for at least `DLY_CYC` reference-clock cycles.
- R4: Bypass mode applies when `bypass_pin_n` is 0 or `bypass_bit` is 0. In bypass mode the outputs enable without `clk_valid` or `pll_locked`.
- R5: In PLL mode (`bypass_pin_n`=1 and `bypass_bit`=1), enabling needs `clk_valid` and `pll_locked` both high for `LOCK_CYC` consecutive cycles. Any cycle where either is low restarts the count.
- R6: While the power-down request is asserted, the outputs never enable.
- R7: The power-down request is asserted when `pdn_pin` is 0 with `pol_inv`=0, or when `pdn_pin` is 1 with `pol_inv`=1.
- R8: While enabled, the outputs park only after the request has been sampled on two consecutive rising edges of `dif_c`, and then on the next falling edge of `dif_c`. An earlier falling edge leaves them enabled.
- R9: After a park the block waits again, and it re-enables once the request is released and the mode conditions hold.
- R10: `drive_sel` is 0 (active) while enabled. In the waiting state it is 1 (true phase high, complement floating) when `pdn_mode_bit`=0, or 2 (both floating) when `pdn_mode_bit`=1. In the power-off and delay states it is 2.
- R11: `lock` rises together with `out_en`. It then stays high regardless of `pll_locked` or `clk_valid`, and clears only on a park or a supply loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply-good flag |
| clk_valid | input | 1 | Input clock present and valid |
| pll_locked | input | 1 | Raw PLL lock status |
| pdn_pin | input | 1 | Power-down request pin, asynchronous |
| pol_inv | input | 1 | Strap that sets the power-down polarity |
| bypass_pin_n | input | 1 | Bypass select pin, low selects bypass |
| bypass_bit | input | 1 | Bypass register bit, 0 selects bypass |
| pdn_mode_bit | input | 1 | Parked drive mode: 0 true phase high, 1 both floating |
| dif_c | input | 1 | Complement output clock level, asynchronous |
| out_en | output | 1 | Global output enable |
| drive_sel | output | 2 | Output drive state: 0 active, 1 true-high, 2 floating |
| lock | output | 1 | Sticky lock flag |

## Verification
If the state machine holds a wrong state, `out_en` and `drive_sel` go wrong together. A premature enable shows within a few cycles of the expected point in the delay and lock-count windows. A park that comes too soon or too late shows on the first falling edge of `dif_c` after the request. A lock flag stuck high or low shows at the next PLL status change or park, because `lock` must track `out_en` exactly. Edge-aligned checks on the slow complement clock separate one-sample from two-sample qualification.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_DELAY = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RUN   = 2'd3
    } pseq_state_e;

    typedef enum logic [1:0] {
        DRV_ACTIVE    = 2'd0,
        DRV_TRUE_HIGH = 2'd1,
        DRV_HIZ       = 2'd2
    } pseq_drive_e;

    typedef struct packed {
        logic pdn;
        logic difc;
    } pseq_async_t;

    function automatic logic pdn_active(input logic raw, input logic inv);
        return ~(raw ^ inv);
    endfunction

    function automatic pseq_drive_e parked_drive(input logic mode);
        return mode ? DRV_HIZ : DRV_TRUE_HIGH;
    endfunction

endpackage

// File: rtl/pseq_sync.sv
module pseq_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= '0;
                else     pipe[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= '0;
                else     pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/pseq_timer.sv
module pseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic [W-1:0] cnt,
    output logic         done
);
    always_ff @(posedge clk) begin
        if (rst || load)          cnt <= load_val;
        else if (run && cnt != 0) cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R3: the countdown never wraps below zero
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> cnt == '0);
endmodule

// File: rtl/pseq_pdn_qual.sv
module pseq_pdn_qual (
    input  logic clk,
    input  logic rst,
    input  logic difc_s,
    input  logic pdn_s,
    output logic park
);
    localparam logic [1:0] ARMED = 2'd2;

    logic       difc_d;
    logic [1:0] hits;
    logic       rise, fall;

    always_ff @(posedge clk) begin
        if (rst) difc_d <= 1'b0;
        else     difc_d <= difc_s;
    end

    assign rise = difc_s & ~difc_d;
    assign fall = ~difc_s & difc_d;

    always_ff @(posedge clk) begin
        if (rst || !pdn_s)             hits <= 2'd0;
        else if (rise && hits != ARMED) hits <= hits + 2'd1;
    end

    assign park = fall && pdn_s && (hits == ARMED);

    // R8: the armed count is reached only on a rising edge of the complement clock
    p_arm_on_rise_r8: assert property (@(posedge clk) disable iff (rst)
        (hits != ARMED) ##1 (hits == ARMED) |-> $past(rise));
    // R9: a released request clears any partial qualification
    p_clear_on_release_r9: assert property (@(posedge clk) disable iff (rst)
        !pdn_s |=> hits == 2'd0);
endmodule

// File: rtl/bufpwr_seq.sv
module bufpwr_seq
    import pseq_pkg::*;
#(
    parameter int DLY_CYC     = 24,
    parameter int LOCK_CYC    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       clk_valid,
    input  logic       pll_locked,
    input  logic       pdn_pin,
    input  logic       pol_inv,
    input  logic       bypass_pin_n,
    input  logic       bypass_bit,
    input  logic       pdn_mode_bit,
    input  logic       dif_c,
    output logic       out_en,
    output logic [1:0] drive_sel,
    output logic       lock
);
    localparam int DLY_W  = $clog2(DLY_CYC + 1);
    localparam int LOCK_W = $clog2(LOCK_CYC + 1);

    pseq_state_e state, state_nx;
    pseq_async_t raw_in, syn_in;
    logic        park, bypass_mode, pll_good, go;
    logic        dly_done, lock_done;
    logic [DLY_W-1:0]  dly_cnt;
    logic [LOCK_W-1:0] lock_cnt;

    assign raw_in.pdn  = pdn_active(pdn_pin, pol_inv);
    assign raw_in.difc = dif_c;

    pseq_sync #(.STAGES(SYNC_STAGES), .W($bits(pseq_async_t))) u_sync (
        .clk(clk), .rst(rst), .d(raw_in), .q(syn_in)
    );

    pseq_pdn_qual u_qual (
        .clk(clk), .rst(rst), .difc_s(syn_in.difc), .pdn_s(syn_in.pdn), .park(park)
    );

    pseq_timer #(.W(DLY_W)) u_dly (
        .clk(clk), .rst(rst),
        .load(state != ST_DELAY), .load_val(DLY_W'(DLY_CYC)),
        .run(1'b1), .cnt(dly_cnt), .done(dly_done)
    );

    assign bypass_mode = !bypass_pin_n || !bypass_bit;
    assign pll_good    = clk_valid && pll_locked;

    pseq_timer #(.W(LOCK_W)) u_lock (
        .clk(clk), .rst(rst),
        .load(state != ST_WAIT || !pll_good), .load_val(LOCK_W'(LOCK_CYC)),
        .run(1'b1), .cnt(lock_cnt), .done(lock_done)
    );

    assign go = !syn_in.pdn && (bypass_mode || (pll_good && lock_done));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   state_nx = ST_DELAY;
            ST_DELAY: if (dly_done) state_nx = ST_WAIT;
            ST_WAIT:  if (go)       state_nx = ST_RUN;
            ST_RUN:   if (park)     state_nx = ST_WAIT;
            default:  state_nx = ST_OFF;
        endcase
        if (!supply_ok) state_nx = ST_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_OFF;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst || !supply_ok)                lock <= 1'b0;
        else if (state == ST_WAIT && go)      lock <= 1'b1;
        else if (state == ST_RUN && park)     lock <= 1'b0;
    end

    assign out_en = (state == ST_RUN);

    always_comb begin
        unique case (state)
            ST_RUN:  drive_sel = DRV_ACTIVE;
            ST_WAIT: drive_sel = parked_drive(pdn_mode_bit);
            default: drive_sel = DRV_HIZ;
        endcase
    end

    // R2: supply loss silences the outputs and clears lock
    p_supply_loss_r2: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (!out_en && !lock && drive_sel == DRV_HIZ));
    // R11: lock is sticky unless parked or supply lost
    p_lock_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (lock && supply_ok && !park) |=> lock);
    // R11: lock never stands without enabled outputs
    p_lock_with_en_r11: assert property (@(posedge clk) disable iff (rst)
        lock |-> out_en);
    // R8: enabled outputs drop only on a qualified park or supply loss
    p_hold_until_park_r8: assert property (@(posedge clk) disable iff (rst)
        (out_en && supply_ok && !park) |=> out_en);
    // R5: in PLL mode enabling requires a completed lock count
    p_pll_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !bypass_mode && !lock_done) |=> !out_en);
    // R10: active drive whenever enabled
    p_drive_active_r10: assert property (@(posedge clk) disable iff (rst)
        out_en |-> drive_sel == DRV_ACTIVE);
endmodule

// File: tb/bufpwr_seq_test.sv
`timescale 1ns/1ps
module bufpwr_seq_test;
    localparam int DLY  = 24;
    localparam int LOCK = 16;

    logic clk = 1'b0;
    logic rst, supply_ok, clk_valid, pll_locked, pdn_pin, pol_inv;
    logic bypass_pin_n, bypass_bit, pdn_mode_bit, dif_c;
    logic out_en, lock;
    logic [1:0] drive_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bufpwr_seq #(.DLY_CYC(DLY), .LOCK_CYC(LOCK), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .clk_valid(clk_valid),
        .pll_locked(pll_locked), .pdn_pin(pdn_pin), .pol_inv(pol_inv),
        .bypass_pin_n(bypass_pin_n), .bypass_bit(bypass_bit),
        .pdn_mode_bit(pdn_mode_bit), .dif_c(dif_c),
        .out_en(out_en), .drive_sel(drive_sel), .lock(lock)
    );

    // {bypass_pin_n, bypass_bit, clk_valid, pll_locked, expected enable}
    localparam logic [4:0] VEC [6] = '{
        5'b0_1_0_0_1, 5'b1_0_0_0_1, 5'b1_1_0_1_0,
        5'b1_1_1_0_0, 5'b1_1_1_1_1, 5'b0_0_1_1_1
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic power_cycle();
        supply_ok = 1'b0;
        tick(3);
        supply_ok = 1'b1;
    endtask

    initial begin
        dif_c = 1'b0;
        forever begin
            tick(8);
            dif_c = ~dif_c;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; supply_ok = 1'b0; clk_valid = 1'b0; pll_locked = 1'b0;
        pdn_pin = 1'b1; pol_inv = 1'b0; bypass_pin_n = 1'b0; bypass_bit = 1'b1;
        pdn_mode_bit = 1'b0;
        tick(4);
        check("R1 out_en in reset", out_en, 0);
        check("R1 lock in reset", lock, 0);
        check("R1 drive_sel in reset", drive_sel, 2);
        rst = 1'b0;

        // R3: settling delay, bypass mode, request released (pin high, pol 0)
        supply_ok = 1'b1;
        tick(DLY - 4);
        check("R3 out_en inside delay", out_en, 0);
        check("R10 drive_sel in delay", drive_sel, 2);
        tick(14);
        check("R3 out_en after delay", out_en, 1);
        check("R11 lock with enable", lock, 1);
        check("R10 drive_sel active", drive_sel, 0);

        // R11: lock ignores PLL status once set
        bypass_pin_n = 1'b1;
        pll_locked = 1'b0; clk_valid = 1'b0;
        tick(5);
        check("R11 lock sticky", lock, 1);
        check("R11 out_en kept", out_en, 1);

        // R2: supply loss
        supply_ok = 1'b0;
        tick(2);
        check("R2 out_en on supply loss", out_en, 0);
        check("R2 lock on supply loss", lock, 0);
        check("R2 drive_sel on supply loss", drive_sel, 2);

        // R4 / R5: mode table
        foreach (VEC[i]) begin
            supply_ok = 1'b0;
            {bypass_pin_n, bypass_bit, clk_valid, pll_locked} = VEC[i][4:1];
            tick(3);
            supply_ok = 1'b1;
            tick(DLY + LOCK + 12);
            check($sformatf("R4 R5 row %0d out_en", i), out_en, int'(VEC[i][0]));
            check($sformatf("R11 row %0d lock", i), lock, int'(VEC[i][0]));
        end

        // R5: a lock dropout restarts the count
        bypass_pin_n = 1'b1; bypass_bit = 1'b1; clk_valid = 1'b1; pll_locked = 1'b0;
        power_cycle();
        tick(DLY + 10);
        pll_locked = 1'b1; tick(10);
        pll_locked = 1'b0; tick(1);
        pll_locked = 1'b1; tick(12);
        check("R5 count restarted", out_en, 0);
        tick(20);
        check("R5 enabled after full count", out_en, 1);

        // R6 / R7: request asserted (pin low, pol 0) blocks enable
        bypass_pin_n = 1'b0; pdn_pin = 1'b0; pdn_mode_bit = 1'b0;
        power_cycle();
        tick(DLY + 30);
        check("R6 R7 blocked by request", out_en, 0);
        check("R10 waiting drive true-high", drive_sel, 1);

        // R7: inverted polarity, pin low now means released
        pol_inv = 1'b1;
        tick(8);
        check("R7 released with pol_inv", out_en, 1);

        // R8: two rising samples then a falling edge
        @(negedge dif_c);
        tick(2);
        pdn_pin = 1'b1;
        @(posedge dif_c);
        @(negedge dif_c);
        tick(6);
        check("R8 held after one sample", out_en, 1);
        @(posedge dif_c);
        @(negedge dif_c);
        tick(6);
        check("R8 parked after two samples", out_en, 0);
        check("R11 lock cleared by park", lock, 0);
        check("R10 parked drive mode 0", drive_sel, 1);
        pdn_mode_bit = 1'b1;
        tick(2);
        check("R10 parked drive mode 1", drive_sel, 2);

        // R9: release and restart
        pdn_pin = 1'b0;
        tick(6);
        check("R9 re-enabled after release", out_en, 1);
        check("R9 drive active again", drive_sel, 0);
        check("R9 lock set again", lock, 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule